// File: doc/BRIEF.md
# Chip-Select Gated Registered Fan-Out Buffer

This block registers a wide command/address-style bus and drives every registered bit onto two identical output banks (A and B), so one input load is split into two output loads. The data path is `DATA_W` lanes wide (22 by default). A small group of per-rank control signals is registered next to it: clock enable, termination enable and active-low select, one of each per rank. These control signals are never gated.

To save switching power, the data lanes can freeze. The data registers keep their value on a rising edge when the gate-enable input is high and every select input is high (no rank selected). The decision uses the select values present at the inputs at that edge, not registered copies. Tying the gate enable low turns the data lanes into plain registers.

An active-low reset, asynchronous to the clock, clears every register at once and takes priority over gating. After reset is released, the outputs stay low until the first rising edge loads input data.

Top module: `csgate_fanout_reg`

## Requirements
- R1: In every cycle, bank A and bank B of each registered signal carry identical values (`dq_a == dq_b`, `clk_en_a == clk_en_b`, `term_a == term_b`, `sel_n_a == sel_n_b`).
- R2: When the data lanes are not held, a rising edge loads `din` into both data banks.
- R3: A rising edge at which `gate_en` is 1 and every bit of `sel_n_in` is 1 leaves both data banks unchanged.
- R4: The hold decision uses the values of `gate_en` and `sel_n_in` sampled at that same edge. Any select bit at 0 on that edge makes the data load, whatever the registered select outputs show.
- R5: While `rst_n` is 0, every output is 0, with or without a clock edge and whatever `gate_en` and `sel_n_in` are.
- R6: Every rising edge out of reset loads `clk_en_in`, `term_in` and `sel_n_in` into their A and B outputs, whether or not the data lanes are held.
- R7: With `gate_en` at 0, the data lanes load `din` on every rising edge, even when all select inputs are 1.
- R8: After `rst_n` rises, all outputs stay 0 until the first following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Enables freezing of the data lanes |
| din | input | DATA_W | Data lanes in |
| clk_en_in | input | RANKS | Per-rank clock-enable in |
| term_in | input | RANKS | Per-rank termination enable in |
| sel_n_in | input | RANKS | Per-rank active-low select in |
| dq_a | output | DATA_W | Data lanes, bank A |
| dq_b | output | DATA_W | Data lanes, bank B |
| clk_en_a | output | RANKS | Clock-enable, bank A |
| clk_en_b | output | RANKS | Clock-enable, bank B |
| term_a | output | RANKS | Termination enable, bank A |
| term_b | output | RANKS | Termination enable, bank B |
| sel_n_a | output | RANKS | Select, bank A |
| sel_n_b | output | RANKS | Select, bank B |

## Verification
The clocked properties assume that inputs change only away from the rising edge, and that reset is asserted and released between edges, so that every edge sees a clean hold decision. The stimulus drives every input on the falling edge. It toggles `rst_n` only in the middle of a clock phase, including once while the data lanes are held. The bench sweeps all eight combinations of gate enable and the two selects, many times each with fresh data words. It keeps a model of the held value worked out from the requirements alone.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    localparam int unsigned RANKS = 2;

    typedef struct packed {
        logic [RANKS-1:0] clk_en;
        logic [RANKS-1:0] term;
        logic [RANKS-1:0] sel_n;
    } ctl_word_t;

    localparam ctl_word_t CTL_ZERO = '{clk_en: '0, term: '0, sel_n: '0};

endpackage

// File: rtl/fbuf_gate.sv
module fbuf_gate
    import fbuf_pkg::*;
(
    input  logic             gate_en,
    input  logic [RANKS-1:0] sel_n_in,
    output logic             load
);

    logic all_idle;

    always_comb begin
        all_idle = &sel_n_in;
        load     = !(gate_en && all_idle);
    end

endmodule

// File: rtl/fbuf_ctl_bank.sv
module fbuf_ctl_bank
    import fbuf_pkg::*;
#(
    parameter int unsigned COPIES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_word_t ctl_in,
    output ctl_word_t ctl_out [COPIES]
);

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        ctl_word_t ctl_d, ctl_q;

        always_comb begin
            ctl_d = ctl_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl_q <= CTL_ZERO;
            else        ctl_q <= ctl_d;
        end

        assign ctl_out[c] = ctl_q;

        AST_CTL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (ctl_q == $past(ctl_in))) else $error("ctl lane missed update"); // R6
    end

endmodule

// File: rtl/fbuf_data_bank.sv
module fbuf_data_bank #(
    parameter int unsigned DATA_W = 22,
    parameter int unsigned COPIES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout [COPIES]
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } lane_state_t;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        lane_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (load) st_d.word = din;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign dout[c] = st_q.word;

        AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (st_q.word == $past(din))) else $error("data not loaded"); // R2
        AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(st_q.word)) else $error("held data changed"); // R3
    end

endmodule

// File: rtl/csgate_fanout_reg.sv
module csgate_fanout_reg
    import fbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic [DATA_W-1:0] din,
    input  logic [RANKS-1:0]  clk_en_in,
    input  logic [RANKS-1:0]  term_in,
    input  logic [RANKS-1:0]  sel_n_in,
    output logic [DATA_W-1:0] dq_a,
    output logic [DATA_W-1:0] dq_b,
    output logic [RANKS-1:0]  clk_en_a,
    output logic [RANKS-1:0]  clk_en_b,
    output logic [RANKS-1:0]  term_a,
    output logic [RANKS-1:0]  term_b,
    output logic [RANKS-1:0]  sel_n_a,
    output logic [RANKS-1:0]  sel_n_b
);

    localparam int unsigned COPIES = 2;

    logic              data_load;
    logic [DATA_W-1:0] dq_copy [COPIES];
    ctl_word_t         ctl_in;
    ctl_word_t         ctl_copy [COPIES];

    fbuf_gate i_gate (
        .gate_en  (gate_en),
        .sel_n_in (sel_n_in),
        .load     (data_load)
    );

    fbuf_data_bank #(.DATA_W(DATA_W), .COPIES(COPIES)) i_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (data_load),
        .din   (din),
        .dout  (dq_copy)
    );

    always_comb begin
        ctl_in.clk_en = clk_en_in;
        ctl_in.term   = term_in;
        ctl_in.sel_n  = sel_n_in;
    end

    fbuf_ctl_bank #(.COPIES(COPIES)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_in  (ctl_in),
        .ctl_out (ctl_copy)
    );

    always_comb begin
        dq_a     = dq_copy[0];
        dq_b     = dq_copy[1];
        clk_en_a = ctl_copy[0].clk_en;
        clk_en_b = ctl_copy[1].clk_en;
        term_a   = ctl_copy[0].term;
        term_b   = ctl_copy[1].term;
        sel_n_a  = ctl_copy[0].sel_n;
        sel_n_b  = ctl_copy[1].sel_n;
    end

    AST_BANKS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_a == dq_b) && (clk_en_a == clk_en_b) && (term_a == term_b) && (sel_n_a == sel_n_b))
        else $error("banks differ"); // R1
    AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sel_n_in) |=> (dq_a == $past(din))) else $error("selected cycle held"); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (dq_a == '0 && dq_b == '0 && clk_en_a == '0 && term_b == '0 && sel_n_a == '0))
        else $error("outputs not cleared in reset"); // R5
    AST_UNGATED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (dq_b == $past(din))) else $error("ungated lane held"); // R7

endmodule

// File: tb/test_csgate_fanout_reg.sv
module test_csgate_fanout_reg;
    localparam int unsigned W  = 22;
    localparam int unsigned RK = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          gate_en;
    logic [W-1:0]  din;
    logic [RK-1:0] clk_en_in, term_in, sel_n_in;
    logic [W-1:0]  dq_a, dq_b;
    logic [RK-1:0] clk_en_a, clk_en_b, term_a, term_b, sel_n_a, sel_n_b;

    int checks = 0;
    int errors = 0;

    logic [W-1:0]  exp_dq;
    logic [RK-1:0] exp_ce, exp_te, exp_sn;

    always #2.5 clk = ~clk;

    csgate_fanout_reg #(.DATA_W(W)) i_csgate_fanout_reg (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .din(din),
        .clk_en_in(clk_en_in), .term_in(term_in), .sel_n_in(sel_n_in),
        .dq_a(dq_a), .dq_b(dq_b), .clk_en_a(clk_en_a), .clk_en_b(clk_en_b),
        .term_a(term_a), .term_b(term_b), .sel_n_a(sel_n_a), .sel_n_b(sel_n_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " dq_a"}, 32'(dq_a), 32'(exp_dq));
        chk({tag, " R1 dq_b"}, 32'(dq_b), 32'(exp_dq));
        chk({tag, " R6 ctl_a"}, 32'({clk_en_a, term_a, sel_n_a}), 32'({exp_ce, exp_te, exp_sn}));
        chk({tag, " R1 ctl_b"}, 32'({clk_en_b, term_b, sel_n_b}), 32'({exp_ce, exp_te, exp_sn}));
    endtask

    // called at a falling edge: drive, cross one rising edge, check at next falling edge
    task automatic step(input string tag, input logic g, input logic [RK-1:0] s, input logic [W-1:0] d);
        gate_en   = g;
        sel_n_in  = s;
        din       = d;
        clk_en_in = RK'($urandom);
        term_in   = RK'($urandom);
        if (!(g && (&s))) exp_dq = d;
        exp_ce = clk_en_in;
        exp_te = term_in;
        exp_sn = s;
        @(posedge clk);
        @(negedge clk);
        chk_all(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; gate_en = 1'b1; din = '1;
        clk_en_in = '1; term_in = '1; sel_n_in = '0;
        exp_dq = '0; exp_ce = '0; exp_te = '0; exp_sn = '0;
        repeat (3) @(negedge clk);
        chk_all("R5 reset with active inputs");

        // R8: release mid-phase, outputs stay low until next rising edge
        #1 rst_n = 1'b1;
        #0.5 chk_all("R8 after release before edge");
        @(negedge clk);
        step("R2 first load", 1'b0, 2'b10, 22'h2a5c3);

        // R2 R3 R4: sweep all gate/select combinations
        for (int rep = 0; rep < 64; rep++) begin
            for (int k = 0; k < 8; k++) begin
                step((k[2] && k[1:0] == 2'b11) ? "R3 hold" : "R4 load",
                     k[2], k[1:0], W'($urandom));
            end
        end

        // R4: registered selects all high, current input selects one rank
        step("R3 prep hold", 1'b1, 2'b11, 22'h155aa);
        step("R3 held again", 1'b1, 2'b11, 22'h0f0f0);
        step("R4 current select decides", 1'b1, 2'b01, 22'h3c3c3);

        // R7: gate disabled, all deselected, data still moves
        for (int i = 0; i < 16; i++)
            step("R7 ungated", 1'b0, 2'b11, W'($urandom));

        // R5: reset while held, asynchronous clear
        step("R3 hold before reset", 1'b1, 2'b11, 22'h1ffff);
        #1 rst_n = 1'b0;
        exp_dq = '0; exp_ce = '0; exp_te = '0; exp_sn = '0;
        #0.5 chk_all("R5 async clear while held");
        @(negedge clk);
        chk_all("R5 clear persists");
        #1 rst_n = 1'b1;
        @(negedge clk);
        gate_en = 1'b1; sel_n_in = 2'b11; din = 22'h12345;
        @(posedge clk); @(negedge clk);
        exp_sn = 2'b11; exp_ce = clk_en_in; exp_te = term_in;
        chk_all("R3 hold keeps zero after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule